// File: doc/BRIEF.md
# Latched serial-to-parallel output driver

This block turns a slow serial bit stream into 32 parallel output control bits. Serial data is clocked into a 32-stage shift register on each falling edge of a serial clock. A latch-enable input copies the shift register into a 32-bit holding stage. The holding stage then reaches the outputs through blanking and polarity logic. A cascade output carries the last shift stage, so several blocks can be chained on one serial line.

The serial clock, serial data and latch enable are asynchronous to the block. They are oversampled by a fast system clock through synchronizers, so the whole block is synchronous to one clock. The system clock must run at least four times as fast as the serial clock. A static direction input selects which end of the register the serial data enters.

Top module: `shift_latch_drv`

## Requirements
- R1: A synchronous active-high `rst` clears the shift register, the holding stage and `drive_o`. One clock after reset is released, `drive_o` depends only on `blank_n_i` and `pol_i` (all zero for `pol_i`=1, all ones for `pol_i`=0), and `cascade_o` is 0.
- R2: The shift register moves by exactly one position per falling edge of `sclk_i` and never on a rising edge. The shift lands on the third rising `clk` edge after `sclk_i` is first sampled low, and the bit stored is the `sdata_i` value sampled on the edge where the low level was first seen.
- R3: With `dir_rev_i`=0 the new bit enters stage 0 and bits move toward stage 31. After 32 falls with the word sent most-significant bit first, stage i holds bit i of the word.
- R4: With `dir_rev_i`=1 the new bit enters stage 31 and bits move toward stage 0. After 32 falls with the word sent least-significant bit first, stage i holds bit i of the word.
- R5: `cascade_o` always equals the stage that leaves the register next: stage 31 for `dir_rev_i`=0 and stage 0 for `dir_rev_i`=1. It has no register between the shift stage and the port.
- R6: `latch_i`, `blank_n_i` and `pol_i` never stall or alter the shift register.
- R7: While the synchronized `latch_i` is high, the holding stage copies the shift register on every clock. Partial contents are exposed in the middle of a shift.
- R8: While the synchronized `latch_i` is low, the holding stage keeps its value, even while new data is shifted.
- R9: With `blank_n_i`=0, all output bits are forced to the same value on the next clock: 0 if `pol_i`=1, and 1 if `pol_i`=0.
- R10: With `blank_n_i`=1, bit i of `drive_o` on the next clock equals bit i of the holding stage if `pol_i`=1, and its inverse if `pol_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Asynchronous serial clock; data moves on its falling edge |
| sdata_i | input | 1 | Asynchronous serial data |
| latch_i | input | 1 | Asynchronous latch enable; high = transparent, low = hold |
| blank_n_i | input | 1 | Active-low blanking |
| pol_i | input | 1 | Output polarity; 1 = follow, 0 = invert |
| dir_rev_i | input | 1 | Static shift direction; 0 = enter at stage 0, 1 = enter at stage 31 |
| drive_o | output | 32 | Output control bits, registered |
| cascade_o | output | 1 | Last shift stage, for chaining |

## Verification
The bench shifts words in both directions while a behavioural model runs beside the design, and compares the two on every clock. It targets three classes of fault. An edge detector that also fires on rising edges would double-shift every bit and scramble each word. A swapped end in either direction would deliver the word bit-reversed or send the wrong stage to `cascade_o`. A holding stage that ignores the latch level would either leak new data while the latch is low or fail to expose the half-shifted word while it is held high. All four blanking and polarity combinations are compared against a known latched word. Latch, blanking and polarity are toggled during a shift to show that the serial path does not change.

// File: rtl/sld_pkg.sv
package sld_pkg;
    localparam int unsigned SLD_WIDTH_DEF = 32;
    localparam int unsigned SLD_SYNC_DEF  = 2;

    typedef enum logic {
        SHIFT_UP   = 1'b0,
        SHIFT_DOWN = 1'b1
    } shift_dir_e;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/sld_shift_core.sv
module sld_shift_core
    import sld_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk_s,
    input  logic         sdata_s,
    input  logic         dir_rev_i,
    output logic         fall_o,
    output logic [W-1:0] bits_o,
    output logic         cascade_o
);
    typedef struct packed {
        logic         sclk_prev;
        logic [W-1:0] bits;
    } core_st_t;

    core_st_t   st_d, st_q;
    shift_dir_e dir;
    logic       fall;

    assign dir  = shift_dir_e'(dir_rev_i);
    assign fall = st_q.sclk_prev & ~sclk_s;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        if (fall) begin
            if (dir == SHIFT_DOWN) begin
                st_d.bits = {sdata_s, st_q.bits[W-1:1]};
            end else begin
                st_d.bits = {st_q.bits[W-2:0], sdata_s};
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fall_o    = fall;
    assign bits_o    = st_q.bits;
    assign cascade_o = (dir == SHIFT_DOWN) ? st_q.bits[0] : st_q.bits[W-1];
endmodule

// File: rtl/sld_hold.sv
module sld_hold #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le_s,
    input  logic [W-1:0] shift_i,
    output logic [W-1:0] hold_o
);
    typedef struct packed {
        logic [W-1:0] hold;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (le_s) begin
            st_d.hold = shift_i;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign hold_o = st_q.hold;
endmodule

// File: rtl/sld_out_stage.sv
module sld_out_stage #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hold_i,
    input  logic         blank_n_i,
    input  logic         pol_i,
    output logic [W-1:0] drive_o
);
    typedef struct packed {
        logic [W-1:0] drive;
    } out_st_t;

    out_st_t      st_d, st_q;
    logic [W-1:0] cell_d;

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic shown;
        assign shown     = hold_i[i] & blank_n_i;
        assign cell_d[i] = pol_i ? shown : ~shown;
    end

    always_comb begin
        st_d       = st_q;
        st_d.drive = cell_d;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign drive_o = st_q.drive;
endmodule

// File: rtl/shift_latch_drv.sv
module shift_latch_drv
    import sld_pkg::*;
#(
    parameter int unsigned WIDTH       = SLD_WIDTH_DEF,
    parameter int unsigned SYNC_STAGES = SLD_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_i,
    input  logic             sdata_i,
    input  logic             latch_i,
    input  logic             blank_n_i,
    input  logic             pol_i,
    input  logic             dir_rev_i,
    output logic [WIDTH-1:0] drive_o,
    output logic             cascade_o
);
    localparam int unsigned NSYNC = 3;

    logic [NSYNC-1:0] raw_in, synced;
    logic             sclk_sync, sdata_sync, le_sync;
    logic             sclk_fall;
    logic [WIDTH-1:0] shift_bits;
    logic [WIDTH-1:0] hold_bits;

    assign raw_in = {latch_i, sdata_i, sclk_i};

    sld_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    assign sclk_sync  = synced[0];
    assign sdata_sync = synced[1];
    assign le_sync    = synced[2];

    sld_shift_core #(.W(WIDTH)) core_i (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (sclk_sync),
        .sdata_s   (sdata_sync),
        .dir_rev_i (dir_rev_i),
        .fall_o    (sclk_fall),
        .bits_o    (shift_bits),
        .cascade_o (cascade_o)
    );

    sld_hold #(.W(WIDTH)) hold_i (
        .clk     (clk),
        .rst     (rst),
        .le_s    (le_sync),
        .shift_i (shift_bits),
        .hold_o  (hold_bits)
    );

    sld_out_stage #(.W(WIDTH)) out_i (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (hold_bits),
        .blank_n_i (blank_n_i),
        .pol_i     (pol_i),
        .drive_o   (drive_o)
    );
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         blank_n_i,
    input logic         pol_i,
    input logic         dir_rev_i,
    input logic         le_s,
    input logic         fall,
    input logic [W-1:0] shift_bits,
    input logic [W-1:0] hold_bits,
    input logic [W-1:0] drive_o
);
    assert_no_shift_without_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(shift_bits));

    assert_up_order_R3: assert property (@(posedge clk) disable iff (rst)
        (fall && !dir_rev_i) |=> shift_bits[W-1:1] == $past(shift_bits[W-2:0]));

    assert_down_order_R4: assert property (@(posedge clk) disable iff (rst)
        (fall && dir_rev_i) |=> shift_bits[W-2:0] == $past(shift_bits[W-1:1]));

    assert_transparent_R7: assert property (@(posedge clk) disable iff (rst)
        le_s |=> hold_bits == $past(shift_bits));

    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !le_s |=> $stable(hold_bits));

    assert_blank_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!blank_n_i && pol_i) |=> drive_o == '0);

    assert_blank_on_R9: assert property (@(posedge clk) disable iff (rst)
        (!blank_n_i && !pol_i) |=> drive_o == '1);

    assert_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (blank_n_i && pol_i) |=> drive_o == $past(hold_bits));

    assert_invert_R10: assert property (@(posedge clk) disable iff (rst)
        (blank_n_i && !pol_i) |=> drive_o == ~$past(hold_bits));
endmodule

bind shift_latch_drv sld_checker #(.W(WIDTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .blank_n_i  (blank_n_i),
    .pol_i      (pol_i),
    .dir_rev_i  (dir_rev_i),
    .le_s       (le_sync),
    .fall       (sclk_fall),
    .shift_bits (shift_bits),
    .hold_bits  (hold_bits),
    .drive_o    (drive_o)
);

// File: tb/shift_latch_drv_tb_top.sv
module shift_latch_drv_tb_top;
    localparam int W        = 32;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b1, sdata = 1'b0, latch = 1'b0;
    logic         blank_n = 1'b1, pol = 1'b1, dir_rev = 1'b0;
    logic [W-1:0] drive;
    logic         cascade;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    string cur_req  = "R1";

    always #10 clk = ~clk;

    shift_latch_drv dut_i (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (sclk),
        .sdata_i   (sdata),
        .latch_i   (latch),
        .blank_n_i (blank_n),
        .pol_i     (pol),
        .dir_rev_i (dir_rev),
        .drive_o   (drive),
        .cascade_o (cascade)
    );

    // behavioural reference: input history per edge, register, hold, output
    logic [W-1:0] m_sr = '0, m_hold = '0, m_drv = '0;
    logic [2:0]   h_sclk = '0;
    logic [1:0]   h_data = '0, h_le = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_sr = '0; m_hold = '0; m_drv = '0;
            h_sclk = '0; h_data = '0; h_le = '0;
        end else begin
            logic         f;
            logic [W-1:0] shown;
            f     = h_sclk[2] && !h_sclk[1];
            shown = blank_n ? m_hold : '0;
            m_drv = pol ? shown : ~shown;
            if (h_le[1]) m_hold = m_sr;
            if (f) begin
                if (dir_rev) m_sr = {h_data[1], m_sr[W-1:1]};
                else         m_sr = {m_sr[W-2:0], h_data[1]};
            end
            h_sclk = {h_sclk[1:0], sclk};
            h_data = {h_data[0], sdata};
            h_le   = {h_le[0], latch};
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // every-clock comparison, away from the edge
    always @(posedge clk) begin
        #5;
        cycles++;
        chk(cur_req, drive, m_drv);
        chk({cur_req, " cascade R5"}, {{(W-1){1'b0}}, cascade},
            {{(W-1){1'b0}}, dir_rev ? m_sr[0] : m_sr[W-1]});
        if (cycles == WATCHDOG) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    task automatic clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_now(input string req, input logic [W-1:0] exp);
        @(posedge clk); #5;
        chk(req, drive, exp);
    endtask

    // one serial bit: data set, falling edge, rising edge; optional noise on controls
    task automatic send_bit(input logic b, input bit noise);
        @(negedge clk); sdata = b;
        if (noise) begin latch = $urandom; blank_n = $urandom; pol = $urandom; end
        clks(2); sclk = 1'b0;
        clks(3); sclk = 1'b1;
        if (noise) begin latch = $urandom; blank_n = $urandom; pol = $urandom; end
        clks(2);
    endtask

    task automatic send_word(input logic [W-1:0] w, input bit lsb_first, input bit noise);
        for (int i = 0; i < W; i++) send_bit(lsb_first ? w[i] : w[W-1-i], noise);
        clks(4);
    endtask

    task automatic pulse_latch();
        @(negedge clk); latch = 1'b1;
        clks(5); latch = 1'b0;
        clks(4);
    endtask

    initial begin
        logic [W-1:0] w1, w2, w3, w4, w5, exp_v;
        void'($urandom(32'h5eed_1234));
        w1 = $urandom; w2 = $urandom; w3 = $urandom; w4 = $urandom; w5 = $urandom;

        clks(4); rst = 1'b0;
        clks(2);
        // R1: cleared state, outputs set only by pol/blank
        check_now("R1 pol=1", '0);
        chk("R1 cascade", {{(W-1){1'b0}}, cascade}, '0);
        @(negedge clk); pol = 1'b0; clks(2);
        check_now("R1 pol=0", '1);
        @(negedge clk); pol = 1'b1;

        // R3: upward shift, MSB first
        cur_req = "R3";
        send_word(w1, 1'b0, 1'b0);
        chk("R5 cascade up", {{(W-1){1'b0}}, cascade}, {{(W-1){1'b0}}, w1[W-1]});
        pulse_latch();
        check_now("R3 word", w1);

        // R10 / R9: all blanking and polarity combinations
        cur_req = "R10";
        @(negedge clk); pol = 1'b0; clks(2);
        check_now("R10 invert", ~w1);
        cur_req = "R9";
        @(negedge clk); blank_n = 1'b0; clks(2);
        check_now("R9 blank pol=0", '1);
        @(negedge clk); pol = 1'b1; clks(2);
        check_now("R9 blank pol=1", '0);
        @(negedge clk); blank_n = 1'b1; clks(2);
        check_now("R10 follow", w1);

        // R8: latch low keeps value while new data shifts
        cur_req = "R8";
        send_word(w2, 1'b0, 1'b0);
        check_now("R8 frozen", w1);
        pulse_latch();
        check_now("R8 new word", w2);

        // R2: one shift per falling edge, none while sclk stays high
        cur_req = "R2";
        send_bit(1'b1, 1'b0); clks(4);
        pulse_latch();
        check_now("R2 single shift", {w2[W-2:0], 1'b1});
        for (int i = 0; i < 8; i++) begin @(negedge clk); sdata = ~sdata; end
        clks(4); pulse_latch();
        check_now("R2 no edge no shift", {w2[W-2:0], 1'b1});

        // R4: downward shift, LSB first
        cur_req = "R4";
        @(negedge clk); dir_rev = 1'b1;
        send_word(w3, 1'b1, 1'b0);
        chk("R5 cascade down", {{(W-1){1'b0}}, cascade}, {{(W-1){1'b0}}, w3[0]});
        pulse_latch();
        check_now("R4 word", w3);

        // R6: control noise during a shift
        cur_req = "R6";
        @(negedge clk); dir_rev = 1'b0;
        send_word(w4, 1'b0, 1'b1);
        @(negedge clk); blank_n = 1'b1; pol = 1'b1; latch = 1'b0;
        pulse_latch();
        check_now("R6 word intact", w4);

        // R7: transparent mode shows the half-shifted word
        cur_req = "R7";
        @(negedge clk); latch = 1'b1;
        for (int i = 0; i < 10; i++) send_bit(w5[W-1-i], 1'b0);
        clks(4);
        exp_v = {w4[W-11:0], w5[W-1:W-10]};
        check_now("R7 partial", exp_v);
        @(negedge clk); latch = 1'b0;

        // mixed random rounds
        cur_req = "R10";
        for (int r = 0; r < 6; r++) begin
            logic [W-1:0] wr;
            logic         dr;
            wr = $urandom; dr = $urandom;
            @(negedge clk); dir_rev = dr;
            send_word(wr, dr, 1'b0);
            pulse_latch();
            check_now(dr ? "R4 random" : "R3 random", wr);
            @(negedge clk); pol = 1'b0; clks(2);
            check_now("R10 random invert", ~wr);
            @(negedge clk); pol = 1'b1;
        end

        clks(4);
        summary();
    end
endmodule